// File: doc/BRIEF.md
# Fault-Checking Double-Width Integer Divider

This block divides a dividend of twice the operand width by a divisor of the operand width. The operand width is picked per operation from four sizes, W/8, W/4, W/2 or W bits (8, 16, 32 or 64 with the default W = 64). Either unsigned or two's-complement signed arithmetic may be chosen. It is a radix-2 restoring divider that produces one quotient bit per clock. The quotient and remainder come back packed the way the accumulator/data register pair expects. An operation with no representable result raises a fault flag instead, and the previous result stays untouched.

Operations enter through a valid/ready pair. `in_ready` is high only while the unit is idle and is not presenting a completion. An operation is taken on a clock edge where `in_valid` and `in_ready` are both high. The caller must hold the operands steady until that edge. While the unit is busy, `in_valid` and the operand pins are ignored. The result side has no back-pressure. `out_valid` is a one-cycle pulse, and the result and fault outputs then hold their values until the next completion. Register writeback and exception delivery belong to the caller.

Top module: `wide_divider`

## Requirements
- R1: After reset `in_ready` is 1, `out_valid` and `res_fault` are 0, and `res_acc` and `res_dat` are 0. `in_ready` is 1 exactly when the unit is idle and `out_valid` is 0. The operation is taken on the edge where `in_valid && in_ready`. Any `in_valid` or operand change while `in_ready` is 0 has no effect.
- R2: `out_valid` is high for exactly one cycle per accepted operation.
- R3: `in_size` selects the operand width N: 0 gives W/8, 1 gives W/4, 2 gives W/2 and 3 gives W. Divisor bits at and above N are ignored.
- R4: For sizes 1 to 3, the dividend is `{in_hi[N-1:0], in_lo[N-1:0]}`. `res_acc` receives the quotient and `res_dat` receives the remainder, each zero-extended from N bits.
- R5: For size 0, the dividend is `in_lo[2N-1:0]` and `in_hi` is ignored. `res_acc[N-1:0]` receives the quotient and `res_acc[2N-1:N]` receives the remainder. All other bits of `res_acc` and all of `res_dat` are 0.
- R6: A divisor whose low N bits are zero raises a fault. `out_valid` and `res_fault` go high in the cycle right after the accepting edge.
- R7: In either mode, a quotient whose magnitude is 2^N or more raises a fault. This includes an upper dividend half (in magnitude) at or above the divisor. The fault has the same one-cycle timing as R6.
- R8: In signed mode, operands are N-bit two's complement. The quotient is truncated toward zero, and a nonzero remainder carries the sign of the dividend.
- R9: In signed mode, a negative quotient below -2^(N-1) faults. A non-negative quotient of 2^(N-1) or more also faults. Both cases are reported with the R10 timing when R7 does not already apply.
- R10: Any other operation completes with `out_valid` high after the (N+1)th rising edge following the accepting edge.
- R11: On a fault, `res_acc` and `res_dat` keep their previous values. `res_fault` is 1 with a faulting completion and 0 with a successful one, and it changes only at a completion.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| in_valid | input | 1 | Operation offered |
| in_ready | output | 1 | Unit can take an operation this cycle |
| in_hi | input | W | Upper dividend half (data register) |
| in_lo | input | W | Lower dividend half (accumulator) |
| in_div | input | W | Divisor |
| in_size | input | 2 | Operand width select |
| in_signed | input | 1 | 1 = signed, 0 = unsigned |
| out_valid | output | 1 | One-cycle completion pulse |
| res_fault | output | 1 | Divide-error flag of the last completion |
| res_acc | output | W | Accumulator result (quotient, or quotient and remainder for size 0) |
| res_dat | output | W | Data result (remainder for sizes 1 to 3) |

## Verification
The hardest cases to reach are the signed results that pass the magnitude precheck but fail the asymmetric bound after the full iteration. Examples are a quotient of exactly +2^(N-1) against -2^(N-1), and the widest size's most negative dividend divided by -1. Random operands almost never produce these. The stimulus therefore builds them directly, for both the smallest and the widest size. It pairs each one with the neighbour that just passes. It also places a fault right after a success, so that the held result can be observed. Junk operands are driven with `in_valid` high during whole operations to show that a busy unit ignores them.

// File: rtl/div_pkg.sv
package div_pkg;

  typedef enum logic [1:0] {
    SZ_EIGHTH  = 2'd0,
    SZ_QUARTER = 2'd1,
    SZ_HALF    = 2'd2,
    SZ_FULL    = 2'd3
  } opsz_e;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_RUN  = 2'd1,
    ST_FIN  = 2'd2
  } div_state_e;

  // Operand width in bits for a size code, given the widest width w.
  function automatic int unsigned op_bits(input int unsigned w, input logic [1:0] sz);
    case (sz)
      2'd0:    return w / 8;
      2'd1:    return w / 4;
      2'd2:    return w / 2;
      default: return w;
    endcase
  endfunction

endpackage

// File: rtl/div_prep.sv
module div_prep
  import div_pkg::*;
#(
  parameter int unsigned W = 64
) (
  input  logic [1:0]   sz,
  input  logic         sgn,
  input  logic [W-1:0] hi,
  input  logic [W-1:0] lo,
  input  logic [W-1:0] dv,
  output logic [W-1:0] dmag,
  output logic [W-1:0] mhi,
  output logic [W-1:0] mlo_al,
  output logic         num_neg,
  output logic         den_neg,
  output logic         pre_fault
);
  localparam int unsigned DW = 2 * W;

  int unsigned    nb;
  logic [W-1:0]   mask;
  logic [DW-1:0]  mask2;
  logic [DW-1:0]  numer;
  logic [DW-1:0]  nmag;
  logic [W-1:0]   den;
  logic [W-1:0]   mlo;

  always_comb begin
    nb    = op_bits(W, sz);
    mask  = {W{1'b1}} >> (W - nb);
    mask2 = {DW{1'b1}} >> (DW - 2 * nb);
    if (sz == SZ_EIGHTH) begin
      numer = {{W{1'b0}}, lo} & mask2;
    end else begin
      numer = ({{W{1'b0}}, hi & mask} << nb) | {{W{1'b0}}, lo & mask};
    end
    den     = dv & mask;
    num_neg = sgn & numer[2 * nb - 1];
    den_neg = sgn & den[nb - 1];
    nmag    = num_neg ? ((~numer + {{(DW-1){1'b0}}, 1'b1}) & mask2) : numer;
    dmag    = den_neg ? ((~den + {{(W-1){1'b0}}, 1'b1}) & mask) : den;
    mhi     = nmag[DW-1:W] | (nmag[W-1:0] >> nb);
    mhi     = (nb == W) ? nmag[DW-1:W] : ((nmag[W-1:0] >> nb) & mask);
    mlo     = nmag[W-1:0] & mask;
    mlo_al  = mlo << (W - nb);
    pre_fault = (dmag == '0) || (mhi >= dmag);
  end

endmodule

// File: rtl/div_step.sv
module div_step #(
  parameter int unsigned W = 64
) (
  input  logic [W-1:0] rem,
  input  logic [W-1:0] lsh,
  input  logic [W-1:0] dmag,
  output logic [W-1:0] rem_nxt,
  output logic [W-1:0] lsh_nxt
);
  logic [W:0] wide;
  logic [W:0] diff;
  logic       take;

  always_comb begin
    wide    = {rem, lsh[W-1]};
    diff    = wide - {1'b0, dmag};
    take    = (wide >= {1'b0, dmag});
    rem_nxt = take ? diff[W-1:0] : wide[W-1:0];
    lsh_nxt = {lsh[W-2:0], take};
  end

endmodule

// File: rtl/div_post.sv
module div_post
  import div_pkg::*;
#(
  parameter int unsigned W = 64
) (
  input  logic [1:0]   sz,
  input  logic         sgn,
  input  logic         num_neg,
  input  logic         den_neg,
  input  logic [W-1:0] quo_raw,
  input  logic [W-1:0] rem_raw,
  output logic [W-1:0] acc,
  output logic [W-1:0] dat,
  output logic         ovf
);
  int unsigned  nb;
  logic [W-1:0] mask;
  logic [W-1:0] lim;
  logic [W-1:0] qmag;
  logic [W-1:0] qv;
  logic [W-1:0] rv;
  logic         qneg;

  always_comb begin
    nb   = op_bits(W, sz);
    mask = {W{1'b1}} >> (W - nb);
    lim  = {{(W-1){1'b0}}, 1'b1} << (nb - 1);
    qmag = quo_raw & mask;
    qneg = num_neg ^ den_neg;
    ovf  = sgn & (qneg ? (qmag > lim) : (qmag >= lim));
    qv   = qneg ? ((~qmag + {{(W-1){1'b0}}, 1'b1}) & mask) : qmag;
    rv   = num_neg ? ((~rem_raw + {{(W-1){1'b0}}, 1'b1}) & mask) : (rem_raw & mask);
    if (sz == SZ_EIGHTH) begin
      acc = (rv << nb) | qv;
      dat = '0;
    end else begin
      acc = qv;
      dat = rv;
    end
  end

endmodule

// File: rtl/wide_divider.sv
module wide_divider
  import div_pkg::*;
#(
  parameter int unsigned W = 64
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         in_valid,
  output logic         in_ready,
  input  logic [W-1:0] in_hi,
  input  logic [W-1:0] in_lo,
  input  logic [W-1:0] in_div,
  input  logic [1:0]   in_size,
  input  logic         in_signed,
  output logic         out_valid,
  output logic         res_fault,
  output logic [W-1:0] res_acc,
  output logic [W-1:0] res_dat
);
  localparam int unsigned CW = $clog2(W) + 1;

  div_state_e   st;
  logic [CW-1:0] cnt;
  logic [W-1:0] rem_q, quo_q, dmag_q;
  logic [1:0]   sz_q;
  logic         sgn_q, nneg_q, dneg_q;

  logic [W-1:0] p_dmag, p_mhi, p_mlo;
  logic         p_nneg, p_dneg, p_fault;
  logic [W-1:0] s_rem, s_quo;
  logic [W-1:0] f_acc, f_dat;
  logic         f_ovf;

  div_prep #(.W(W)) u_prep (
    .sz(in_size), .sgn(in_signed), .hi(in_hi), .lo(in_lo), .dv(in_div),
    .dmag(p_dmag), .mhi(p_mhi), .mlo_al(p_mlo),
    .num_neg(p_nneg), .den_neg(p_dneg), .pre_fault(p_fault)
  );

  div_step #(.W(W)) u_step (
    .rem(rem_q), .lsh(quo_q), .dmag(dmag_q),
    .rem_nxt(s_rem), .lsh_nxt(s_quo)
  );

  div_post #(.W(W)) u_post (
    .sz(sz_q), .sgn(sgn_q), .num_neg(nneg_q), .den_neg(dneg_q),
    .quo_raw(quo_q), .rem_raw(rem_q),
    .acc(f_acc), .dat(f_dat), .ovf(f_ovf)
  );

  assign in_ready = (st == ST_IDLE) && !out_valid;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st        <= ST_IDLE;
      cnt       <= '0;
      rem_q     <= '0;
      quo_q     <= '0;
      dmag_q    <= '0;
      sz_q      <= '0;
      sgn_q     <= 1'b0;
      nneg_q    <= 1'b0;
      dneg_q    <= 1'b0;
      out_valid <= 1'b0;
      res_fault <= 1'b0;
      res_acc   <= '0;
      res_dat   <= '0;
    end else begin
      out_valid <= 1'b0;
      case (st)
        ST_IDLE: begin
          if (in_valid && in_ready) begin
            if (p_fault) begin
              out_valid <= 1'b1;
              res_fault <= 1'b1;
            end else begin
              st     <= ST_RUN;
              cnt    <= CW'(op_bits(W, in_size));
              rem_q  <= p_mhi;
              quo_q  <= p_mlo;
              dmag_q <= p_dmag;
              sz_q   <= in_size;
              sgn_q  <= in_signed;
              nneg_q <= p_nneg;
              dneg_q <= p_dneg;
            end
          end
        end
        ST_RUN: begin
          rem_q <= s_rem;
          quo_q <= s_quo;
          cnt   <= cnt - 1'b1;
          if (cnt == {{(CW-1){1'b0}}, 1'b1}) st <= ST_FIN;
        end
        ST_FIN: begin
          out_valid <= 1'b1;
          res_fault <= f_ovf;
          if (!f_ovf) begin
            res_acc <= f_acc;
            res_dat <= f_dat;
          end
          st <= ST_IDLE;
        end
        default: st <= ST_IDLE;
      endcase
    end
  end

endmodule

// File: rtl/wide_divider_checker.sv
module wide_divider_checker #(
  parameter int unsigned W = 64
) (
  input logic         clk,
  input logic         rst_n,
  input logic         in_valid,
  input logic         in_ready,
  input logic [W-1:0] in_div,
  input logic [1:0]   in_size,
  input logic         out_valid,
  input logic         res_fault,
  input logic [W-1:0] res_acc,
  input logic [W-1:0] res_dat
);
  logic [W-1:0] dmask;
  always_comb begin
    case (in_size)
      2'd0:    dmask = {W{1'b1}} >> (W - W / 8);
      2'd1:    dmask = {W{1'b1}} >> (W - W / 4);
      2'd2:    dmask = {W{1'b1}} >> (W - W / 2);
      default: dmask = {W{1'b1}};
    endcase
  end

  AST_ACCEPT_DROPS_READY: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && in_ready |=> !in_ready); // R1
  AST_NO_READY_AT_DONE: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> !in_ready); // R1
  AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |=> !out_valid); // R2
  AST_ZERO_DIVISOR: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && in_ready && ((in_div & dmask) == '0) |=> out_valid && res_fault); // R6
  AST_FAULT_KEEPS_RESULT: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && res_fault |-> $stable(res_acc) && $stable(res_dat)); // R11
  AST_RESULT_ONLY_AT_DONE: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(res_acc) || !$stable(res_dat) |-> out_valid && !res_fault); // R11
  AST_FLAG_ONLY_AT_DONE: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(res_fault) |-> out_valid); // R11

endmodule

bind wide_divider wide_divider_checker #(.W(W)) u_chk (
  .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
  .in_div(in_div), .in_size(in_size), .out_valid(out_valid),
  .res_fault(res_fault), .res_acc(res_acc), .res_dat(res_dat)
);

// File: tb/wide_divider_test.sv
module wide_divider_test;
  localparam int W = 64;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         in_valid = 1'b0;
  logic         in_ready;
  logic [W-1:0] in_hi = '0, in_lo = '0, in_div = '0;
  logic [1:0]   in_size = '0;
  logic         in_signed = 1'b0;
  logic         out_valid, res_fault;
  logic [W-1:0] res_acc, res_dat;

  int checks = 0;
  int fails = 0;
  int cyc = 0;
  string cur_req = "R1";

  wide_divider #(.W(W)) uut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_hi(in_hi), .in_lo(in_lo), .in_div(in_div), .in_size(in_size),
    .in_signed(in_signed), .out_valid(out_valid), .res_fault(res_fault),
    .res_acc(res_acc), .res_dat(res_dat)
  );

  always #5 clk = ~clk;

  // Behavioural reference: expected result from 128-bit arithmetic.
  task automatic ref_eval(input logic [63:0] hi, input logic [63:0] lo,
                          input logic [63:0] dv, input logic [1:0] sz,
                          input logic sg, output bit early, output bit flt,
                          output logic [63:0] acc, output logic [63:0] dat);
    int n;
    logic [127:0] m1, m2, dd, du, qu, ru;
    logic signed [127:0] a, b, q, r, qm, lim;
    logic [63:0] qv, rv;
    n = 8 << sz;
    m1 = (128'd1 << n) - 128'd1;
    m2 = (n == 64) ? {128{1'b1}} : ((128'd1 << (2 * n)) - 128'd1);
    dd = (sz == 2'd0) ? ({64'd0, lo} & m2)
                      : ((({64'd0, hi} & m1) << n) | ({64'd0, lo} & m1));
    du = {64'd0, dv} & m1;
    early = 1'b0; flt = 1'b0; acc = '0; dat = '0;
    if (du == 0) begin early = 1'b1; flt = 1'b1; return; end
    if (!sg) begin
      qu = dd / du; ru = dd % du;
      if (qu >= (128'd1 << n)) begin early = 1'b1; flt = 1'b1; return; end
      qv = qu[63:0]; rv = ru[63:0];
    end else begin
      a = dd << (128 - 2 * n); a = a >>> (128 - 2 * n);
      b = du << (128 - n);     b = b >>> (128 - n);
      q = a / b; r = a % b;
      qm = (q < 0) ? -q : q;
      lim = 128'sd1 <<< (n - 1);
      if (qm >= (128'sd1 <<< n)) begin early = 1'b1; flt = 1'b1; return; end
      if (q >= lim || q < -lim) begin flt = 1'b1; return; end
      qv = q[63:0] & m1[63:0]; rv = r[63:0] & m1[63:0];
    end
    if (sz == 2'd0) begin acc = (rv << n) | qv; dat = '0; end
    else begin acc = qv; dat = rv; end
  endtask

  // Cycle model: updated at each rising edge from the stable inputs.
  int          m_cnt = 0;
  bit          m_valid = 0, m_fault = 0, p_flt = 0;
  logic [63:0] m_acc = '0, m_dat = '0, p_acc = '0, p_dat = '0;

  always @(posedge clk) begin
    bit rdy, e, f;
    logic [63:0] a, d;
    if (!rst_n) begin
      m_cnt = 0; m_valid = 0; m_fault = 0; m_acc = '0; m_dat = '0;
    end else begin
      rdy = (m_cnt == 0) && !m_valid;
      m_valid = 0;
      if (m_cnt > 0) begin
        m_cnt--;
        if (m_cnt == 0) begin
          m_valid = 1; m_fault = p_flt;
          if (!p_flt) begin m_acc = p_acc; m_dat = p_dat; end
        end
      end
      if (rdy && in_valid) begin
        ref_eval(in_hi, in_lo, in_div, in_size, in_signed, e, f, a, d);
        if (e) begin m_valid = 1; m_fault = 1; end
        else begin m_cnt = (8 << in_size) + 1; p_flt = f; p_acc = a; p_dat = d; end
      end
    end
  end

  task automatic chk(input string what, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s actual=%h expected=%h", cur_req, what, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (rst_n) begin
      chk("in_ready (R1)", 64'(in_ready), 64'((m_cnt == 0) && !m_valid));
      chk("out_valid (R2/R10)", 64'(out_valid), 64'(m_valid));
      chk("res_fault (R11)", 64'(res_fault), 64'(m_fault));
      chk("res_acc", res_acc, m_acc);
      chk("res_dat", res_dat, m_dat);
    end
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      fails++;
      $display("FAIL watchdog expired actual=%0d expected<150000", cyc);
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  task automatic op(input string req, input logic [1:0] sz, input logic sg,
                    input logic [63:0] hi, input logic [63:0] lo,
                    input logic [63:0] dv, input bit junk);
    cur_req = req;
    in_size = sz; in_signed = sg; in_hi = hi; in_lo = lo; in_div = dv;
    in_valid = 1'b1;
    while (!in_ready) @(negedge clk);
    @(negedge clk);
    if (junk) begin
      in_hi = {$urandom, $urandom}; in_lo = {$urandom, $urandom};
      in_div = '0; in_size = 2'($urandom); in_signed = 1'($urandom);
    end else begin
      in_valid = 1'b0;
    end
    while (!out_valid) @(negedge clk);
    in_valid = 1'b0;
    @(negedge clk);
  endtask

  initial begin
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    cur_req = "R1";
    chk("reset in_ready R1", 64'(in_ready), 64'd1);
    chk("reset res_acc R1", res_acc, 64'd0);
    // R4 unsigned, sizes 1..3
    op("R4", 2'd1, 0, 64'h0012, 64'h3456, 64'h0100, 0);
    op("R4", 2'd2, 0, 64'h1, 64'h0, 64'h3, 0);
    op("R4", 2'd3, 0, 64'h5, 64'hFFFF_0000_1234_5678, 64'h1_2345_6789, 0);
    // R5 and R3: byte packing with garbage in ignored bits
    op("R5", 2'd0, 0, 64'hDEAD_BEEF_0000_0001, 64'hABCD_0000_0000_0403, 64'hFFFF_FF07, 0);
    // R6 zero divisor (low bits zero), following a success
    op("R6", 2'd0, 0, 64'h0, 64'h0010, 64'hFF00, 0);
    op("R6", 2'd3, 1, 64'h0, 64'h7, 64'h0, 0);
    // R7 unsigned overflow and its boundary
    op("R7", 2'd0, 0, 64'h0, 64'h0100, 64'h01, 0);
    op("R7", 2'd3, 0, 64'h10, 64'h0, 64'h10, 0);
    op("R7", 2'd3, 0, 64'hF, 64'hFFFF_FFFF_FFFF_FFFF, 64'h10, 0);
    // R8 signed truncation and remainder sign
    op("R8", 2'd1, 1, 64'hFFFF, 64'hFFF9, 64'h2, 0);
    op("R8", 2'd2, 1, 64'h0, 64'h7, 64'hFFFF_FFFE, 0);
    op("R8", 2'd0, 1, 64'h0, 64'hFF85, 64'h07, 0);
    // R9 asymmetric signed bounds
    op("R9", 2'd0, 1, 64'h0, 64'hFF00, 64'h02, 0);
    op("R9", 2'd0, 1, 64'h0, 64'h0100, 64'h02, 0);
    op("R9", 2'd0, 1, 64'h0, 64'h0100, 64'hFE, 0);
    op("R9", 2'd0, 1, 64'h0, 64'hFF00, 64'hFE, 0);
    op("R9", 2'd3, 1, 64'hFFFF_FFFF_FFFF_FFFF, 64'h8000_0000_0000_0000, 64'h1, 0);
    op("R9", 2'd3, 1, 64'hFFFF_FFFF_FFFF_FFFF, 64'h8000_0000_0000_0000,
       64'hFFFF_FFFF_FFFF_FFFF, 0);
    // R1 busy unit ignores junk offers; R10 latency checked by the model
    op("R1", 2'd2, 0, 64'h3, 64'h9999_0000, 64'h7777_7777, 1);
    op("R10", 2'd3, 1, 64'h0, 64'h1234_5678_9ABC_DEF0, 64'h3, 1);
    // R3 random mix across sizes and modes
    for (int i = 0; i < 200; i++) begin
      logic [63:0] h;
      h = {$urandom, $urandom} >> ($urandom % 64);
      op("R3", 2'($urandom), 1'($urandom), h, {$urandom, $urandom},
         {$urandom, $urandom} >> ($urandom % 64), bit'($urandom % 4 == 0));
    end
    repeat (3) @(negedge clk);
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

endmodule